// File: doc/BRIEF.md
# Linked-List Descriptor Queue Manager

This block keeps many hardware FIFO queues of descriptor pointers. It does not give each queue its own storage. Every queue is a singly linked list threaded through one shared link memory, and that memory has one entry for each descriptor. Software enqueues a descriptor by issuing a push command that carries the descriptor address for a queue. It dequeues the oldest descriptor of a queue by issuing a pop command. The answer to a pop arrives on the response port one cycle later.

A pushed word has two parts. Bits 3:0 are a size hint, and the bits above them are the descriptor pointer. The pointer becomes a link index through a single descriptor region, which is configured by a base address, a start index and a power-of-two descriptor size. A pop converts the index back into an address and returns the stored hint in the low four bits.

For each queue the block keeps an entry count and a byte total, which is the sum of the hints of the descriptors now in the queue. Both can be read through a query port. Each queue also has a threshold byte. Bit 7 of that byte selects the comparison and bits 6:0 hold the level. The result of the comparison is driven as one status bit per queue. The block accepts one command per cycle through a single command port.

Top module: `desc_queue_mgr`

## Requirements
- R1: After reset every queue has entry count 0 and byte total 0, every status bit is 0, and `rsp_valid` is 0.
- R2: A push (`op_cmd`=0) to queue q raises q's entry count by 1 and its byte total by `op_data[3:0]`. Only `op_data[AW-1:4]` is used as the pointer.
- R3: A pop (`op_cmd`=1) from a non-empty queue drives `rsp_valid`=1 in the next cycle. `rsp_data` then holds the oldest descriptor of that queue, with its pointer bits and hint exactly as they were pushed (first in, first out).
- R4: A pop from a non-empty queue lowers the entry count by 1 and the byte total by the hint of the descriptor it returns.
- R5: A pop from an empty queue drives `rsp_valid`=1 with `rsp_data`=0 in the next cycle, and the queue's count and byte total stay unchanged.
- R6: Queues share the link memory and do not affect each other. Interleaved pushes and pops on different queues keep each queue's own order and totals.
- R7: A threshold write (`op_cmd`=2) stores `op_data[7:0]` for queue q. With bit 7 set, q's status bit is 1 when count >= bits 6:0. With bit 7 clear, it is 1 when count < bits 6:0.
- R8: A descriptor at address `cfg_base + k*2^cfg_size_log2` maps to link index `cfg_start + k`. Every k with `cfg_start + k < NLINK` round-trips correctly, including the last index. `cfg_size_log2` must be at least 4.
- R9: Commands may be issued on consecutive cycles. A pop issued in every cycle gets a response in each following cycle. `rsp_valid` is 1 only in the cycle after a pop.
- R10: `stat_count` and `stat_bytes` show the count and byte total of `stat_queue`. They reflect every command from the cycle after that command is accepted. The count never exceeds NLINK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Region base address |
| cfg_start | input | IW | Link index of the region's first descriptor |
| cfg_size_log2 | input | 5 | log2 of the descriptor size in bytes (>= 4) |
| op_valid | input | 1 | Command present this cycle |
| op_cmd | input | 2 | 0 push, 1 pop, 2 threshold write, 3 no effect |
| op_queue | input | QW | Target queue |
| op_data | input | AW | Push word (pointer and hint) or threshold byte |
| rsp_valid | output | 1 | Pop response valid |
| rsp_data | output | AW | Popped descriptor word, or 0 when the queue was empty |
| stat_queue | input | QW | Queue selected for the query |
| stat_count | output | CW | Entry count of the selected queue |
| stat_bytes | output | BW | Byte total of the selected queue |
| q_status | output | NQ | Threshold status bit for each queue |

## Verification
Two situations are hard to reach from the ports. The first is a queue that empties and refills while other queues keep threading their links through neighbouring entries of the shared memory. The second is a descriptor that sits at the very top link index under a non-zero start index and base. Long constrained-random runs reach the first. They concentrate commands on a few queues, recycle descriptors from a small free pool, and mix in pops of empty queues. Directed steps reach the second: the block is reset with a second region setting, and the descriptor at the highest index is pushed and popped alongside the one at the start index.

// File: rtl/desc_queue_mgr.sv
module desc_queue_mgr #(
  parameter int NQ    = 64,
  parameter int NLINK = 1024,
  parameter int AW    = 32,
  localparam int QW = $clog2(NQ),
  localparam int IW = $clog2(NLINK),
  localparam int CW = $clog2(NLINK + 1),
  localparam int BW = CW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [IW-1:0] cfg_start,
  input  logic [4:0]    cfg_size_log2,
  input  logic          op_valid,
  input  logic [1:0]    op_cmd,
  input  logic [QW-1:0] op_queue,
  input  logic [AW-1:0] op_data,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_data,
  input  logic [QW-1:0] stat_queue,
  output logic [CW-1:0] stat_count,
  output logic [BW-1:0] stat_bytes,
  output logic [NQ-1:0] q_status
);

  logic [IW-1:0] head   [NQ];
  logic [IW-1:0] tail   [NQ];
  logic [CW-1:0] cnt    [NQ];
  logic [BW-1:0] bytes  [NQ];
  logic [7:0]    thr    [NQ];
  logic [IW-1:0] next_mem [NLINK];
  logic [3:0]    hint_mem [NLINK];

  logic push, pop, set_thr, q_empty;
  logic [AW-1:0] ptr, off, pop_addr;
  logic [IW-1:0] push_idx, hd, rel;
  logic [3:0]    push_hint, pop_hint;

  assign push     = op_valid && op_cmd == 2'd0;
  assign pop      = op_valid && op_cmd == 2'd1;
  assign set_thr  = op_valid && op_cmd == 2'd2;
  assign q_empty  = cnt[op_queue] == '0;

  assign ptr       = {op_data[AW-1:4], 4'b0000};
  assign off       = (ptr - cfg_base) >> cfg_size_log2;
  assign push_idx  = cfg_start + off[IW-1:0];
  assign push_hint = op_data[3:0];

  assign hd       = head[op_queue];
  assign rel      = hd - cfg_start;
  assign pop_hint = hint_mem[hd];
  assign pop_addr = (cfg_base + (AW'(rel) << cfg_size_log2)) | AW'(pop_hint);

  assign stat_count = cnt[stat_queue];
  assign stat_bytes = bytes[stat_queue];

  for (genvar g = 0; g < NQ; g++) begin : g_status
    assign q_status[g] = thr[g][7] ? (cnt[g] >= CW'(thr[g][6:0]))
                                   : (cnt[g] <  CW'(thr[g][6:0]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      for (int i = 0; i < NQ; i++) begin
        head[i]  <= '0;
        tail[i]  <= '0;
        cnt[i]   <= '0;
        bytes[i] <= '0;
        thr[i]   <= '0;
      end
    end else begin
      rsp_valid <= pop;
      rsp_data  <= (pop && !q_empty) ? pop_addr : '0;
      if (push) begin
        if (q_empty) head[op_queue] <= push_idx;
        tail[op_queue]  <= push_idx;
        cnt[op_queue]   <= cnt[op_queue] + 1'b1;
        bytes[op_queue] <= bytes[op_queue] + BW'(push_hint);
      end
      if (pop && !q_empty) begin
        head[op_queue]  <= next_mem[hd];
        cnt[op_queue]   <= cnt[op_queue] - 1'b1;
        bytes[op_queue] <= bytes[op_queue] - BW'(pop_hint);
      end
      if (set_thr) thr[op_queue] <= op_data[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      hint_mem[push_idx] <= push_hint;
      if (!q_empty) next_mem[tail[op_queue]] <= push_idx;
    end
  end

  p_empty_pop_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && q_empty) |=> (rsp_valid && rsp_data == '0));

  p_push_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> cnt[$past(op_queue)] == $past(cnt[op_queue]) + 1'b1);

  p_pop_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !q_empty) |=> cnt[$past(op_queue)] == $past(cnt[op_queue]) - 1'b1);

  p_rsp_after_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(pop));

  p_empty_no_bytes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_count == '0) |-> (stat_bytes == '0));

  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_count <= CW'(NLINK));

  p_size_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_size_log2 >= 5'd4);

endmodule

// File: tb/desc_queue_mgr_bench.sv
module desc_queue_mgr_bench;
  localparam int NQ = 64, NLINK = 1024, AW = 32;
  localparam int QW = $clog2(NQ), IW = $clog2(NLINK);
  localparam int CW = $clog2(NLINK + 1), BW = CW + 4;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] cfg_base = 32'h8000_0000;
  logic [IW-1:0] cfg_start = '0;
  logic [4:0] cfg_size_log2 = 5'd4;
  logic op_valid = 0;
  logic [1:0] op_cmd = 2'd3;
  logic [QW-1:0] op_queue = '0, stat_queue = '0;
  logic [AW-1:0] op_data = '0;
  logic rsp_valid;
  logic [AW-1:0] rsp_data;
  logic [CW-1:0] stat_count;
  logic [BW-1:0] stat_bytes;
  logic [NQ-1:0] q_status;

  always #4 clk = ~clk;

  desc_queue_mgr u_desc_queue_mgr (.*);

  int checks = 0, errors = 0;
  int mq[NQ][$];
  int mbytes[NQ];
  int mthr[NQ];
  bit inuse[NLINK];

  function automatic logic [AW-1:0] addr_of(int k, int hint);
    return (cfg_base + (AW'(k) << cfg_size_log2)) | AW'(hint);
  endfunction

  function automatic bit exp_status(int count, int t);
    return (t & 8'h80) ? (count >= (t & 8'h7f)) : (count < (t & 8'h7f));
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_q(int q, string req);
    stat_queue = QW'(q);
    #1;
    chk(stat_count == CW'(mq[q].size()), {req, " count"}, stat_count, mq[q].size());
    chk(stat_bytes == BW'(mbytes[q]), {req, " bytes"}, stat_bytes, mbytes[q]);
    chk(q_status[q] == exp_status(mq[q].size(), mthr[q]), {req, " status"},
        q_status[q], exp_status(mq[q].size(), mthr[q]));
  endtask

  task automatic issue(int cmd, int q, logic [AW-1:0] d);
    op_valid = 1; op_cmd = 2'(cmd); op_queue = QW'(q); op_data = d;
    @(posedge clk);
    @(negedge clk);
    op_valid = 0; op_cmd = 2'd3;
  endtask

  task automatic do_push(int q, int k, int hint, string req);
    issue(0, q, addr_of(k, hint));
    mq[q].push_back(k * 16 + hint);
    mbytes[q] += hint;
    inuse[k] = 1;
    check_q(q, req);
  endtask

  task automatic do_pop(int q, string req);
    logic [AW-1:0] exp;
    int e;
    exp = '0;
    if (mq[q].size() > 0) begin
      e = mq[q].pop_front();
      exp = addr_of(e / 16, e % 16);
      mbytes[q] -= e % 16;
      inuse[e / 16] = 0;
    end
    issue(1, q, '0);
    chk(rsp_valid === 1'b1, {req, " rsp_valid"}, rsp_valid, 1);
    chk(rsp_data === exp, {req, " rsp_data"}, rsp_data, exp);
    check_q(q, req);
  endtask

  task automatic do_thr(int q, int t, string req);
    issue(2, q, AW'(t));
    mthr[q] = t;
    check_q(q, req);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int q = 0; q < NQ; q++) begin
      mq[q].delete(); mbytes[q] = 0; mthr[q] = 0;
    end
    for (int i = 0; i < NLINK; i++) inuse[i] = 0;
  endtask

  task automatic random_phase(int n, int span);
    for (int i = 0; i < n; i++) begin
      int q, r, k;
      q = ($urandom_range(0, 9) == 0) ? $urandom_range(0, NQ - 1) : $urandom_range(0, 7);
      r = $urandom_range(0, 99);
      if (r < 52) begin
        k = $urandom_range(0, span - 1);
        if (!inuse[k]) do_push(q, k, $urandom_range(0, 15), "R6 random push R2");
        else do_pop(q, "R6 random pop R3");
      end else if (r < 92) begin
        do_pop(q, "R6 random pop R4");
      end else begin
        do_thr(q, $urandom_range(0, 255) & 8'h87, "R7 random thr");
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid === 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(q_status === '0, "R1 status", q_status, 0);
    check_q(0, "R1"); check_q(63, "R1");

    // R5 pop from empty
    do_pop(5, "R5 empty pop");
    // R2 R10 pushes, R3 R4 FIFO pops
    do_push(5, 3, 7, "R2 push");
    do_push(5, 9, 0, "R2 push hint0");
    do_push(5, 1, 15, "R10 push");
    do_pop(5, "R3 fifo"); do_pop(5, "R4 fifo"); do_pop(5, "R3 last");
    do_pop(5, "R5 empty again");
    // R6 interleave queues
    do_push(0, 10, 2, "R6"); do_push(63, 11, 4, "R6");
    do_push(0, 12, 6, "R6"); do_push(63, 13, 8, "R6");
    do_pop(63, "R6"); do_pop(0, "R6"); do_pop(0, "R6"); do_pop(63, "R6");
    // R7 threshold modes
    do_thr(7, 8'h83, "R7 ge");
    do_push(7, 20, 1, "R7"); do_push(7, 21, 1, "R7"); do_push(7, 22, 1, "R7 reach");
    do_thr(7, 8'h02, "R7 lt");
    do_pop(7, "R7"); do_pop(7, "R7 below");
    do_pop(7, "R7");
    // R9 back-to-back pops on an empty queue and a filled one
    do_push(2, 30, 3, "R9"); do_push(2, 31, 5, "R9");
    do_pop(2, "R9 b2b"); do_pop(2, "R9 b2b"); do_pop(2, "R9 b2b empty");

    random_phase(4000, 64);

    // R8 second region setting: non-zero start, 64-byte descriptors
    cfg_base = 32'h1000_0000; cfg_start = IW'(100); cfg_size_log2 = 5'd6;
    do_reset();
    @(negedge clk);
    do_push(40, NLINK - 101, 9, "R8 top index");
    do_push(40, 0, 4, "R8 start index");
    do_pop(40, "R8 top pop"); do_pop(40, "R8 start pop");
    random_phase(2000, NLINK - 100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule